// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a synchronous static RAM whose words are 36 bits wide. Each word is split into four 9-bit byte lanes: lane i occupies bits [9i+8:9i], with eight data bits in [9i+7:9i] and the lane's parity bit at 9i+8. Reads are pipelined through an output register. Writes take their data late, at the same distance from the command as read data. Because of this, a bus master can issue reads and writes in any order on consecutive cycles, and the data bus never needs an idle cycle to change direction.

A command is presented with `ld` high and is sampled on a rising clock edge while `cke` is high. With `ld` low, the block continues the previous access as a burst inside an aligned group of four words, in either linear or interleaved order. A write whose data has not yet reached the array is forwarded to a read of the same address, lane by lane. The output enable and the snooze input act without waiting for the clock. For simulation the data bus is split into `din`, `dout` and a drive-enable `dout_en`.

Top module: `pipe_sram`

## Requirements
- R1: During and after synchronous reset (`rst_n` low at a rising edge), `dout_en` is 0 and `dout` is all zeros until a read's data cycle.
- R2: A read command accepted at enabled edge E loads the word into the output register at the next enabled edge E+1. The word is presented on `dout` until enabled edge E+2, where the master samples it.
- R3: A write command accepted at enabled edge E takes its data from `din` at enabled edge E+2. The master therefore drives the data in the cycle just before E+2, and the write cycle never drives `dout_en`.
- R4: A write updates lane i (bits [9i+8:9i]) only when `be[i]` was 1 with that command. Lanes whose enable was 0 keep their old contents, and `be`=0000 changes nothing.
- R5: Reads and writes in any mix, issued on every consecutive cycle, all complete correctly with no idle cycle.
- R6: A read whose array access meets a same-address write still waiting for its data returns that write's enabled lanes from `din`, and the array contents for the other lanes.
- R7: `dout_en` is 1 only in a read-data cycle with `oe`=1 and the read selected. Whenever `dout_en` is 0, `dout` is all zeros.
- R8: `oe`=0 suppresses `dout_en` within the same cycle without changing any stored state. A later read still returns correct data.
- R9: An edge with `cke`=0 changes no state: the pipeline, the pending writes, the output register and the burst state all hold, and with `oe` unchanged `dout`/`dout_en` stay the same.
- R10: `ld`=0 following an active access continues it with the same direction (`ce` ignored), taking `be` fresh each beat. For the k-th beat after the start, the low two address bits are (start+k) mod 4 when `burst_lin`=1 and start XOR (k mod 4) when `burst_lin`=0. The upper address bits are kept.
- R11: While `zz`=1, no command is accepted, any burst is ended, and a following `ld`=0 cycle does nothing.
- R12: `ld`=1 with `ce`=0 is a deselect: no access takes place and any burst is ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; 0 freezes all state |
| ce | input | 1 | Chip select, sampled when `ld`=1 |
| zz | input | 1 | Snooze; blocks new commands, asynchronous |
| ld | input | 1 | 1 = load a new command, 0 = advance the burst |
| we | input | 1 | 1 = write, 0 = read, sampled with `ld`=1 |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| be | input | 4 | Byte-lane write enables |
| addr | input | AW | Word address |
| din | input | 36 | Write data, taken at the second enabled edge after the command |
| oe | input | 1 | Output enable, asynchronous |
| dout | output | 36 | Read data, zeros when not driven |
| dout_en | output | 1 | Bus drive enable |

## Verification
On every cycle the assertions check the gating of the bus by `oe` and the zero value of `dout` when it is not driven. They also check the read-data cycle that follows an accepted read, and the absence of drive after write, deselect and snooze cycles. Finally they check that a frozen edge leaves the outputs unchanged. Data correctness needs the bench's scenarios against a reference memory. These cover byte-lane merging, same-address forwarding, both burst orders from every starting offset, and write-then-read ordering across random clock-enable gaps.

// File: rtl/pipe_sram_pkg.sv
// Shared constants and the command record passed from issue to pipeline.
// Assumes four lanes of nine bits (eight data bits plus parity at the top).
package pipe_sram_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic             vld;
        logic             wr;
        logic [LANES-1:0] be;
    } op_t;
endpackage

// File: rtl/pipe_sram_issue.sv
// Command issue stage: decodes load, deselect, snooze and burst-advance
// cycles and registers the resulting access. Holds the burst state.
// Assumes AW >= 2 so that a four-word burst group exists.
module pipe_sram_issue
    import pipe_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             ce,
    input  logic             zz,
    input  logic             ld,
    input  logic             we,
    input  logic             burst_lin,
    input  logic [LANES-1:0] be,
    input  logic [AW-1:0]    addr,
    output op_t              s1_op,
    output logic [AW-1:0]    s1_addr
);
    logic          act, act_n, bwr, bwr_n;
    logic [AW-1:0] base, base_n, addr_n;
    logic [1:0]    cnt, cnt_n, cnt_inc, lo;
    op_t           op_n;

    assign cnt_inc = cnt + 2'd1;
    assign lo      = burst_lin ? (base[1:0] + cnt_inc) : (base[1:0] ^ cnt_inc);

    // Decide the access of this cycle and the next burst state.
    always_comb begin
        op_n   = '0;
        addr_n = s1_addr;
        act_n  = act;
        bwr_n  = bwr;
        base_n = base;
        cnt_n  = cnt;
        if (zz) begin
            act_n = 1'b0;
        end else if (ld) begin
            if (ce) begin
                op_n.vld = 1'b1;
                op_n.wr  = we;
                op_n.be  = be;
                addr_n   = addr;
                act_n    = 1'b1;
                bwr_n    = we;
                base_n   = addr;
                cnt_n    = 2'd0;
            end else begin
                act_n = 1'b0;
            end
        end else if (act) begin
            op_n.vld = 1'b1;
            op_n.wr  = bwr;
            op_n.be  = be;
            addr_n   = {base[AW-1:2], lo};
            cnt_n    = cnt_inc;
        end
    end

    // Register the access and burst state on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op   <= '0;
            s1_addr <= '0;
            act     <= 1'b0;
            bwr     <= 1'b0;
            base    <= '0;
            cnt     <= 2'd0;
        end else if (cke) begin
            s1_op   <= op_n;
            s1_addr <= addr_n;
            act     <= act_n;
            bwr     <= bwr_n;
            base    <= base_n;
            cnt     <= cnt_n;
        end
    end
endmodule

// File: rtl/pipe_sram_array.sv
// Storage array: one memory per byte lane, a masked write port and an
// unregistered read port. Assumes the caller does any forwarding.
module pipe_sram_array
    import pipe_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              cke,
    input  logic              wr_en,
    input  logic [AW-1:0]     waddr,
    input  logic [LANES-1:0]  wbe,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        // Update this lane when its enable is set on an enabled edge.
        always_ff @(posedge clk) begin
            if (cke && wr_en && wbe[g]) begin
                lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];
    end
endmodule

// File: rtl/pipe_sram.sv
// Top: issue stage, late-write stage, lane-wise forwarding and the read
// output register. Read data and write data share the bus cycle two enabled
// edges after the command. Assumes din is valid before that second edge.
module pipe_sram
    import pipe_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              ce,
    input  logic              zz,
    input  logic              ld,
    input  logic              we,
    input  logic              burst_lin,
    input  logic [LANES-1:0]  be,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] din,
    input  logic              oe,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);
    op_t               s1_op;
    logic [AW-1:0]     s1_addr;
    logic              s2_vld;
    logic [AW-1:0]     s2_addr;
    logic [LANES-1:0]  s2_be;
    logic [WORD_W-1:0] arr_q, merged, rd_q;
    logic              rd_vld, hit;

    pipe_sram_issue #(.AW(AW)) u_issue (
        .clk(clk), .rst_n(rst_n), .cke(cke), .ce(ce), .zz(zz), .ld(ld),
        .we(we), .burst_lin(burst_lin), .be(be), .addr(addr),
        .s1_op(s1_op), .s1_addr(s1_addr)
    );

    pipe_sram_array #(.AW(AW)) u_array (
        .clk(clk), .cke(cke), .wr_en(s2_vld), .waddr(s2_addr), .wbe(s2_be),
        .wdata(din), .raddr(s1_addr), .rdata(arr_q)
    );

    // Hold a write for one more edge while its data is on the way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld  <= 1'b0;
            s2_addr <= '0;
            s2_be   <= '0;
        end else if (cke) begin
            s2_vld  <= s1_op.vld & s1_op.wr;
            s2_addr <= s1_addr;
            s2_be   <= s1_op.be;
        end
    end

    assign hit = s2_vld && (s2_addr == s1_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign merged[g*LANE_W +: LANE_W] = (hit && s2_be[g]) ?
            din[g*LANE_W +: LANE_W] : arr_q[g*LANE_W +: LANE_W];
    end

    // Load the output register for a read one enabled edge after command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld <= 1'b0;
            rd_q   <= '0;
        end else if (cke) begin
            rd_vld <= s1_op.vld & ~s1_op.wr;
            if (s1_op.vld && !s1_op.wr) begin
                rd_q <= merged;
            end
        end
    end

    assign dout_en = rd_vld & oe;
    assign dout    = dout_en ? rd_q : '0;
endmodule

// File: rtl/pipe_sram_chk.sv
// Protocol checker for pipe_sram, attached by bind below. Observes ports only.
module pipe_sram_chk
    import pipe_sram_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              ce,
    input logic              zz,
    input logic              ld,
    input logic              we,
    input logic              oe,
    input logic [WORD_W-1:0] dout,
    input logic              dout_en
);
    AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> oe); // R7
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0)); // R7
    AST_READ_DATA_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && ld && ce && !we && !zz) ##1 cke |=> (dout_en == oe)); // R2
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && ld && ce && we && !zz) ##1 cke |=> !dout_en); // R3
    AST_SNOOZE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && zz) ##1 cke |=> !dout_en); // R11
    AST_DESELECT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && ld && !ce && !zz) ##1 cke |=> !dout_en); // R12
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(oe) -> ($stable(dout_en) && $stable(dout)))); // R9
endmodule

bind pipe_sram pipe_sram_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cke(cke), .ce(ce), .zz(zz), .ld(ld),
    .we(we), .oe(oe), .dout(dout), .dout_en(dout_en)
);

// File: tb/tb_pipe_sram.sv
// Bench: reference memory plus per-edge schedules of read captures and
// write commits, derived from the latency requirements.
module tb_pipe_sram;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic clk, rst_n, cke, ce, zz, ld, we, burst_lin, oe, dout_en;
    logic [3:0]  be;
    logic [AW-1:0] addr;
    logic [35:0] din, dout;

    pipe_sram #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .ce(ce), .zz(zz), .ld(ld),
        .we(we), .burst_lin(burst_lin), .be(be), .addr(addr), .din(din),
        .oe(oe), .dout(dout), .dout_en(dout_en)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int checks = 0, errors = 0, ecount = 0;
    string cur_req = "R1";
    logic [35:0] ref_mem [DEPTH];
    logic rs_v [8]; logic [AW-1:0] rs_a [8];
    logic ws_v [8]; logic [AW-1:0] ws_a [8]; logic [3:0] ws_be [8]; logic [35:0] ws_d [8];
    logic exp_vld = 1'b0;
    logic [35:0] exp_q = '0;
    logic b_act = 1'b0, b_wr = 1'b0;
    logic [AW-1:0] b_base = '0;
    logic [1:0] b_cnt = '0;

    function automatic logic [35:0] rnd36();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[35:0];
    endfunction

    task automatic chk(input bit ok, input string what, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, model at posedge, check at next negedge.
    task automatic step(input bit i_cke, i_ce, i_ld, i_we, i_lin, i_zz, i_oe,
                        input logic [3:0] i_be, input logic [AW-1:0] i_a);
        int s;
        logic op_v, op_w;
        logic [AW-1:0] op_a;
        logic [1:0] ci, lo;
        s = ecount % 8;
        cke = i_cke; ce = i_ce; ld = i_ld; we = i_we; burst_lin = i_lin;
        zz = i_zz; oe = i_oe; be = i_be; addr = i_a;
        din = ws_v[s] ? ws_d[s] : rnd36();
        op_v = 1'b0; op_w = 1'b0; op_a = '0;
        if (i_cke) begin
            if (i_zz) b_act = 1'b0;
            else if (i_ld) begin
                if (i_ce) begin
                    op_v = 1'b1; op_w = i_we; op_a = i_a;
                    b_act = 1'b1; b_wr = i_we; b_base = i_a; b_cnt = 2'd0;
                end else b_act = 1'b0;
            end else if (b_act) begin
                ci = b_cnt + 2'd1;
                lo = i_lin ? (b_base[1:0] + ci) : (b_base[1:0] ^ ci);
                op_v = 1'b1; op_w = b_wr; op_a = {b_base[AW-1:2], lo}; b_cnt = ci;
            end
        end
        @(posedge clk);
        if (i_cke) begin
            if (ws_v[s]) begin
                for (int g = 0; g < 4; g++)
                    if (ws_be[s][g]) ref_mem[ws_a[s]][g*9 +: 9] = ws_d[s][g*9 +: 9];
                ws_v[s] = 1'b0;
            end
            exp_vld = rs_v[s];
            if (rs_v[s]) exp_q = ref_mem[rs_a[s]];
            rs_v[s] = 1'b0;
            if (op_v && op_w) begin
                ws_v[(ecount+2)%8] = 1'b1; ws_a[(ecount+2)%8] = op_a;
                ws_be[(ecount+2)%8] = i_be; ws_d[(ecount+2)%8] = rnd36();
            end else if (op_v) begin
                rs_v[(ecount+1)%8] = 1'b1; rs_a[(ecount+1)%8] = op_a;
            end
            ecount++;
        end
        @(negedge clk);
        chk(dout_en === (exp_vld & i_oe), "dout_en", {35'd0, dout_en}, {35'd0, exp_vld & i_oe});
        if (exp_vld && i_oe) chk(dout === exp_q, "read data", dout, exp_q);
        else chk(dout === 36'd0, "idle bus", dout, 36'd0);
    endtask

    task automatic rd(input logic [AW-1:0] a, input bit o = 1'b1);
        step(1, 1, 1, 0, 0, 0, o, 4'hf, a);
    endtask
    task automatic wr(input logic [AW-1:0] a, input logic [3:0] b);
        step(1, 1, 1, 1, 0, 0, 1, b, a);
    endtask
    task automatic nop();
        step(1, 0, 1, 0, 0, 0, 1, 4'h0, '0);
    endtask
    task automatic adv(input bit lin, input logic [3:0] b);
        step(1, 0, 0, 0, lin, 0, 1, b, '0);
    endtask
    task automatic rnd_step(input bit gaps);
        logic [31:0] r;
        r = $urandom();
        step(gaps ? (r[1:0] != 2'd0) : 1'b1, r[2] | r[3], ~(r[4] & r[5]), r[6],
             r[7], (r[11:8] == 4'd0), r[12] | r[13], r[17:14], r[18+AW-1:18]);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin rs_v[i] = 1'b0; ws_v[i] = 1'b0; end
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        rst_n = 1'b0; cke = 1'b1; ce = 1'b0; zz = 1'b0; ld = 1'b1; we = 1'b0;
        burst_lin = 1'b0; oe = 1'b1; be = '0; addr = '0; din = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        chk(dout_en === 1'b0, "reset dout_en", {35'd0, dout_en}, 36'd0);
        chk(dout === 36'd0, "reset dout", dout, 36'd0);
        rst_n = 1'b1;
        nop(); nop();

        cur_req = "R3";   // fill every word back to back
        for (int a = 0; a < DEPTH; a++) wr(a[AW-1:0], 4'hf);
        nop(); nop();
        cur_req = "R2";   // read every word back to back
        for (int a = 0; a < DEPTH; a++) rd(a[AW-1:0]);
        nop(); nop();

        cur_req = "R4";   // every lane mask, including none
        for (int b = 0; b < 16; b++) wr(b[AW-1:0], b[3:0]);
        nop(); nop();
        for (int b = 0; b < 16; b++) rd(b[AW-1:0]);
        nop(); nop();

        cur_req = "R5";   // turnarounds in every pattern
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r;
            r = $urandom();
            if (i % 3 == 2 ? r[0] : (i % 2 == 0)) wr(r[AW+3:4], r[3:0]);
            else rd(r[AW+3:4]);
        end
        nop(); nop();

        cur_req = "R6";   // same-address write then read at distances 1 and 2
        for (int i = 0; i < 40; i++) begin
            logic [AW-1:0] a;
            logic [3:0] b;
            a = 6'($urandom()); b = 4'($urandom());
            wr(a, b);
            if (i % 3 == 1) nop();
            if (i % 3 == 2) wr(a, ~b);
            rd(a);
        end
        nop(); nop();

        cur_req = "R8";   // output enable low on read-data cycles
        for (int i = 0; i < 20; i++) rd(6'(i), i % 2 == 0);
        nop();
        cur_req = "R7";
        for (int i = 0; i < 20; i++) rd(6'(i));
        nop(); nop();

        cur_req = "R9";   // random clock-enable gaps
        for (int i = 0; i < 400; i++) rnd_step(1'b1);
        nop(); nop(); nop();

        cur_req = "R10";  // both orders, every start offset, both directions
        for (int l = 0; l < 2; l++)
            for (int o = 0; o < 4; o++) begin
                logic [AW-1:0] base;
                base = 6'(8 * (l * 4 + o) / 2 + o);
                wr(base, 4'hf); adv(l[0], 4'hf); adv(l[0], 4'h5); adv(l[0], 4'hf);
                rd(base); adv(l[0], 4'h0); adv(l[0], 4'h0); adv(l[0], 4'h0); adv(l[0], 4'h0);
                nop();
                for (int k = 0; k < 4; k++) rd({base[AW-1:2], 2'(k)});
                nop(); nop();
            end

        cur_req = "R11";  // snooze blocks a write and ends a burst
        step(1, 1, 1, 1, 0, 1, 1, 4'hf, 6'd3);
        nop(); nop(); rd(6'd3); nop();
        rd(6'd8); step(1, 1, 1, 0, 0, 1, 1, 4'h0, 6'd8); adv(1'b1, 4'h0); nop(); nop();

        cur_req = "R12";  // deselect ends a burst
        rd(6'd12); nop(); adv(1'b1, 4'hf); adv(1'b0, 4'hf); nop(); nop();
        wr(6'd20, 4'hf); nop(); adv(1'b1, 4'hf); nop(); nop();
        for (int k = 20; k < 24; k++) rd(6'(k));
        nop(); nop();

        cur_req = "R5";   // long random mix
        for (int i = 0; i < 2000; i++) rnd_step(1'b0);
        for (int i = 0; i < 3; i++) nop();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule